// File: doc/BRIEF.md
# Network Management Vector Accumulator

This block gathers the network management vectors found in frames received during one communication cycle of a time-triggered bus controller. An upstream stage presents each valid vector as a 12-byte array together with a one-clock strobe. A hidden working accumulator merges every vector of the running cycle by bitwise OR.

When the cycle-end pulse arrives, the accumulated value is masked to the configured byte count and copied into a bank of six 16-bit host registers. In the same clock the accumulator restarts for the next cycle. The host reads the bank through a combinational index-addressed read port. Between two cycle ends the bank keeps showing the previous cycle's merged result.

Top module: `nmv_accum_top`

## Requirements
- R1: After reset, every bank register reads 0x0000.
- R2: Vector byte i is carried on `vec_data[8*i+7:8*i]`. Register k shows byte 2k in bits 15:8 and byte 2k+1 in bits 7:0.
- R3: All vectors strobed within one cycle are merged by bitwise OR into the value published at that cycle's end.
- R4: The bank changes only in the clock where `cycle_end` is high. At all other times it holds the last published value.
- R5: A cycle that receives no vector publishes all zeros at its end.
- R6: A vector strobed in the same clock as `cycle_end` is left out of the value being published and is counted toward the following cycle.
- R7: With `cfg_len` = L in the range 0 to 12, bytes L and above of the published value read as zero.
- R8: A `cfg_len` value above 12 acts as 12. A value of 0 publishes an all-zero bank.
- R9: A read index of 6 or 7 returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| vec_valid | input | 1 | Strobe marking a valid received vector |
| vec_data | input | 96 | Received vector, byte i at bits 8i+7:8i |
| cycle_end | input | 1 | One-clock pulse at the end of a communication cycle |
| cfg_len | input | 4 | Number of vector bytes in use |
| rd_idx | input | 3 | Index of the bank register to read |
| rd_data | output | 16 | Contents of the selected bank register |

## Verification
A corrupted accumulator cannot be seen at the ports until the next `cycle_end`. It then shows up as wrong bits in the registers read right after that pulse, so the bench reads the whole bank after every cycle boundary. A corrupted bank, or a bank that changes off the boundary, shows up on the very next read. For that reason the bench also reads the bank in the middle of cycles while vectors are still arriving. Masking and byte-placement faults show up as particular register halves that are nonzero or swapped.

// File: rtl/nmv_pkg.sv
package nmv_pkg;
   // Operation applied to the working accumulator in one clock
   typedef enum logic [1:0] {
      ACC_HOLD    = 2'd0,
      ACC_MERGE   = 2'd1,
      ACC_RESTART = 2'd2
   } acc_op_e;
endpackage

// File: rtl/nmv_len_mask.sv
module nmv_len_mask #(
   parameter int VEC_BYTES = 12,
   parameter int LEN_W     = 4
) (
   input  logic [LEN_W-1:0]     len,
   output logic [VEC_BYTES-1:0] byte_en
);
   if ((1 << LEN_W) <= VEC_BYTES) begin : g_len_too_narrow
      $error("LEN_W cannot express the full vector length");
   end

   // A byte is in use when its index lies below the length; larger lengths saturate naturally
   for (genvar i = 0; i < VEC_BYTES; i++) begin : g_byte
      localparam logic [LEN_W-1:0] IDX = LEN_W'(i);
      assign byte_en[i] = (len > IDX);
   end
endmodule

// File: rtl/nmv_accum.sv
module nmv_accum
   import nmv_pkg::*;
#(
   parameter int VEC_BYTES = 12,
   parameter int BYTE_W    = 8,
   localparam int VEC_W    = VEC_BYTES * BYTE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld,
   input  logic [VEC_W-1:0] data,
   input  logic             boundary,
   output logic [VEC_W-1:0] acc
);
   acc_op_e op;

   always_comb begin
      if (boundary)  op = ACC_RESTART;
      else if (vld)  op = ACC_MERGE;
      else           op = ACC_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
      end else begin
         unique case (op)
            ACC_RESTART: acc <= vld ? data : '0;
            ACC_MERGE:   acc <= acc | data;
            default:     acc <= acc;
         endcase
      end
   end

   // R5
   acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && !vld) |=> (acc == '0));
   // R6
   acc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && vld) |=> (acc == $past(data)));
   // R3
   acc_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> ((acc & $past(acc)) == $past(acc)));
endmodule

// File: rtl/nmv_bank.sv
module nmv_bank #(
   parameter int NUM_REGS = 6,
   parameter int REG_W    = 16,
   parameter int BYTE_W   = 8,
   parameter int ADDR_W   = 3,
   localparam int BPR       = REG_W / BYTE_W,
   localparam int VEC_BYTES = NUM_REGS * BPR,
   localparam int VEC_W     = VEC_BYTES * BYTE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 capture,
   input  logic [VEC_W-1:0]     acc,
   input  logic [VEC_BYTES-1:0] byte_en,
   input  logic [ADDR_W-1:0]    rd_idx,
   output logic [REG_W-1:0]     rd_data
);
   if (REG_W % BYTE_W != 0) begin : g_bad_reg_w
      $error("REG_W must be a whole number of bytes");
   end
   if ((1 << ADDR_W) < NUM_REGS) begin : g_bad_addr_w
      $error("ADDR_W too narrow for NUM_REGS");
   end

   logic [VEC_W-1:0]  bank_q;
   logic [VEC_W-1:0]  en_bits;
   logic [REG_W-1:0]  reg_view [NUM_REGS];

   for (genvar i = 0; i < VEC_BYTES; i++) begin : g_byte
      assign en_bits[i*BYTE_W +: BYTE_W] = {BYTE_W{byte_en[i]}};
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bank_q[i*BYTE_W +: BYTE_W] <= '0;
         else if (capture)
            bank_q[i*BYTE_W +: BYTE_W] <= byte_en[i] ? acc[i*BYTE_W +: BYTE_W] : '0;
      end
   end

   // Lower-numbered byte sits in the upper half of each register
   for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      for (genvar j = 0; j < BPR; j++) begin : g_lane
         assign reg_view[k][REG_W-1-j*BYTE_W -: BYTE_W] = bank_q[(k*BPR+j)*BYTE_W +: BYTE_W];
      end
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_REGS; k++) begin
         if ({1'b0, rd_idx} == (ADDR_W+1)'(k)) rd_data = reg_view[k];
      end
   end

   // R4
   bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(bank_q));
   // R7
   masked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> ((bank_q & ~$past(en_bits)) == '0));
   // R9
   oob_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, rd_idx} >= (ADDR_W+1)'(NUM_REGS)) |-> (rd_data == '0));
endmodule

// File: rtl/nmv_accum_top.sv
module nmv_accum_top #(
   parameter int NUM_REGS = 6,
   parameter int REG_W    = 16,
   parameter int BYTE_W   = 8,
   parameter int LEN_W    = 4,
   localparam int VEC_BYTES = NUM_REGS * (REG_W / BYTE_W),
   localparam int VEC_W     = VEC_BYTES * BYTE_W,
   localparam int ADDR_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vec_valid,
   input  logic [VEC_W-1:0]  vec_data,
   input  logic              cycle_end,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic [ADDR_W-1:0] rd_idx,
   output logic [REG_W-1:0]  rd_data
);
   logic [VEC_W-1:0]     acc;
   logic [VEC_BYTES-1:0] byte_en;

   nmv_len_mask #(.VEC_BYTES(VEC_BYTES), .LEN_W(LEN_W)) u_mask (
      .len     (cfg_len),
      .byte_en (byte_en)
   );

   nmv_accum #(.VEC_BYTES(VEC_BYTES), .BYTE_W(BYTE_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .vld      (vec_valid),
      .data     (vec_data),
      .boundary (cycle_end),
      .acc      (acc)
   );

   nmv_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (cycle_end),
      .acc     (acc),
      .byte_en (byte_en),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );
endmodule

// File: tb/test_nmv_accum_top.sv
module test_nmv_accum_top;
   localparam int NB = 12;
   localparam int NR = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          vec_valid = 1'b0;
   logic [95:0]   vec_data = '0;
   logic          cycle_end = 1'b0;
   logic [3:0]    cfg_len = 4'd12;
   logic [2:0]    rd_idx = '0;
   logic [15:0]   rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [95:0] acc_m = '0;
   logic [95:0] bank_m = '0;

   nmv_accum_top i_nmv_accum_top (
      .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_data(vec_data),
      .cycle_end(cycle_end), .cfg_len(cfg_len), .rd_idx(rd_idx), .rd_data(rd_data)
   );

   always #10 clk = ~clk;

   function automatic logic [95:0] mask_f(logic [95:0] a, int len);
      logic [95:0] r = a;
      for (int i = 0; i < NB; i++) if (i >= len) r[8*i +: 8] = 8'h00;
      return r;
   endfunction

   function automatic logic [15:0] reg_f(logic [95:0] b, int k);
      return {b[8*(2*k) +: 8], b[8*(2*k+1) +: 8]};
   endfunction

   function automatic logic [95:0] rnd_vec();
      logic [95:0] v;
      for (int i = 0; i < 3; i++) v[32*i +: 32] = $urandom;
      // sparse bits so OR merging is visible
      for (int i = 0; i < 3; i++) v[32*i +: 32] = v[32*i +: 32] & $urandom;
      return v;
   endfunction

   // One clock: drive at negedge, model the edge, return at next negedge
   task automatic step(bit v, logic [95:0] d, bit ce);
      vec_valid = v; vec_data = d; cycle_end = ce;
      @(posedge clk);
      if (ce) begin
         bank_m = mask_f(acc_m, int'(cfg_len));
         acc_m  = v ? d : '0;
      end else if (v) begin
         acc_m = acc_m | d;
      end
      @(negedge clk);
      vec_valid = 0; cycle_end = 0;
   endtask

   task automatic check_bank(string tag);
      for (int k = 0; k < 8; k++) begin
         logic [15:0] exp;
         rd_idx = 3'(k);
         #1;
         exp = (k < NR) ? reg_f(bank_m, k) : 16'h0000;
         checks++;
         if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s idx %0d actual %h expected %h", tag, k, rd_data, exp);
         end
      end
   endtask

   initial begin
      logic [95:0] a;
      logic [95:0] b;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_bank("R1 reset");

      // R2: byte placement, distinct bytes
      cfg_len = 4'd12;
      for (int i = 0; i < NB; i++) a[8*i +: 8] = 8'(i + 1);
      step(1, a, 0);
      step(0, '0, 1);
      check_bank("R2 mapping");

      // R4: bank holds while vectors arrive mid-cycle
      b = 96'hF0F0_0000_1111_2222_0000_8001;
      step(1, b, 0);
      check_bank("R4 hold mid-cycle");
      // R3: OR of several vectors
      step(1, 96'h0F00_0000_0000_0000_0000_0002, 0);
      step(0, '0, 0);
      step(1, 96'h0000_00FF_0000_0000_0000_0004, 0);
      check_bank("R4 hold before end");
      step(0, '0, 1);
      check_bank("R3 OR merge");

      // R5: empty cycle publishes zero
      step(0, '0, 0);
      step(0, '0, 1);
      check_bank("R5 empty cycle");

      // R6: vector at boundary goes to next cycle
      step(1, 96'hAAAA_5555_0000_0000_1234_5678, 1);
      check_bank("R6 boundary vector excluded");
      step(0, '0, 1);
      check_bank("R6 boundary vector next cycle");

      // R7: partial length
      cfg_len = 4'd5;
      step(1, {96{1'b1}}, 0);
      step(0, '0, 1);
      check_bank("R7 len 5");
      cfg_len = 4'd1;
      step(1, {96{1'b1}}, 0);
      step(0, '0, 1);
      check_bank("R7 len 1");

      // R8: saturation and zero length
      cfg_len = 4'd15;
      step(1, {96{1'b1}}, 0);
      step(0, '0, 1);
      check_bank("R8 len 15");
      cfg_len = 4'd0;
      step(1, {96{1'b1}}, 0);
      step(0, '0, 1);
      check_bank("R8 len 0");

      // Random cycles, R3 R7 R9 under mixed patterns
      for (int c = 0; c < 60; c++) begin
         int n = $urandom_range(0, 4);
         if (($urandom & 3) == 0) cfg_len = 4'($urandom_range(0, 15));
         for (int j = 0; j < n; j++) begin
            if ($urandom & 1) step(1, rnd_vec(), 0);
            else step(0, '0, 0);
         end
         if (c % 7 == 3) check_bank("R4 random mid-cycle");
         step(($urandom & 1) == 1, rnd_vec(), 1);
         check_bank("R3 random cycle");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual hung expected done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule